// File: doc/BRIEF.md
# Smart card wait and guard timer

This block times the character exchange with a contact smart card in units of the elementary time unit (ETU). A single 24-bit waiting timer guards the card side. It has three selectable modes: the gap between characters the card sends, the gap between the end of a reader block and the card's answer, and the gap before the answer-to-reset. When the loaded limit is reached, a sticky timeout interrupt is raised.

On the reader side the block gates the transmitter. Between two transmitted characters it keeps the transmit-permit low for the base 12-ETU character time plus a programmable extra guard. After a received character it keeps the permit low for a programmable block guard. The transmitter only starts a character while the permit is high.

Its inputs are a one-cycle ETU strobe, start-bit events from the transceiver, the loaded limit, the mode and the two guard values. All counting advances only on the ETU strobe.

Top module: `sc_wait_guard_timer`

## Requirements
- R1: After reset timeout_irq_o is low, tx_permit_o is high and no waiting timer runs.
- R2: Mode code 2'b10 (initial wait) starts counting at the load pulse. timeout_irq_o rises in the cycle after the ETU strobe on which the count reaches the loaded limit. A received start bit stops the timer.
- R3: Mode code 2'b00 (character wait) starts or restarts the count from zero on every received start bit while armed. The interrupt follows the same limit rule as R2.
- R4: Mode code 2'b01 (block wait) starts or restarts the count only on a transmit start flagged as the last character. A transmit start not so flagged is ignored, and a received start bit stops the timer.
- R5: timeout_irq_o stays high until an irq_clr_i pulse. When an expiry and a clear fall in the same cycle, the interrupt stays high.
- R6: After expiry the timer stays stopped and ignores start events until it is loaded again.
- R7: A transmit start drops tx_permit_o in the next cycle. The permit stays low until 12 plus egt_i ETU strobes have followed that start.
- R8: A received start bit drops tx_permit_o until bgt_i ETU strobes have followed it. A bgt_i of 0 adds no hold-off.
- R9: tx_permit_o is high only when both the character guard and the block guard have elapsed.
- R10: Clock cycles without an ETU strobe advance neither the waiting timer nor the guard counts.
- R11: Mode code 2'b11 disables the waiting timer. A load in this mode arms nothing.
- R12: A loaded limit of 0 expires on the first ETU strobe after the timer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| etu_tick_i | input | 1 | One-cycle strobe per ETU |
| rx_start_i | input | 1 | Start bit of a received character |
| tx_start_i | input | 1 | Leading edge of a transmitted character |
| tx_last_i | input | 1 | Qualifies tx_start_i as the last character of a block |
| mode_i | input | 2 | Waiting mode, captured at load |
| wait_load_i | input | 1 | Load pulse for limit and mode |
| wait_val_i | input | 24 | Waiting limit in ETUs |
| irq_clr_i | input | 1 | Clears the timeout interrupt |
| egt_i | input | 8 | Extra guard ETUs between transmitted characters |
| bgt_i | input | 8 | Block guard ETUs from a received character to transmission |
| timeout_irq_o | output | 1 | Sticky timeout interrupt |
| tx_permit_o | output | 1 | Transmitter may start a character |

## Verification
The expiry that sets the interrupt and a firmware clear pulse can land on the same clock edge. The bench brings a timer to one strobe before its limit while an earlier interrupt is still pending. It then drives the final ETU strobe and irq_clr_i together and expects the interrupt to remain high. A following lone clear must drop it. The bench also overlaps a transmit start with a received start bit to show that the longer of the two guards decides when the permit returns.

// File: rtl/sc_wgt_pkg.sv
package sc_wgt_pkg;
  typedef enum logic [1:0] {
    MODE_CWT = 2'b00,
    MODE_BWT = 2'b01,
    MODE_IWT = 2'b10,
    MODE_OFF = 2'b11
  } wait_mode_e;

  localparam int unsigned CHAR_ETU = 12;
endpackage

// File: rtl/sc_etu_cnt.sv
module sc_etu_cnt #(
  parameter int unsigned W       = 24,
  parameter bit          RST_MAX = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= RST_MAX ? MAX : '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R10: saturate, never wrap
  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && en_i && !clr_i) |=> (cnt_q == MAX));
endmodule

// File: rtl/sc_wait_ctrl.sv
module sc_wait_ctrl
  import sc_wgt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             etu_tick_i,
  input  logic             rx_start_i,
  input  logic             tx_start_i,
  input  logic             tx_last_i,
  input  wait_mode_e       mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             irq_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             irq_o
);
  wait_mode_e       mode_q;
  logic [CNT_W-1:0] limit_q;
  logic             armed_q, run_q, irq_q;
  logic             restart, stop, expire;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_i} + 1'b1;

  always_comb begin
    restart = armed_q && ((mode_q == MODE_CWT && rx_start_i) ||
                          (mode_q == MODE_BWT && tx_start_i && tx_last_i));
    stop    = armed_q && mode_q != MODE_CWT && rx_start_i;
    expire  = etu_tick_i && run_q && !load_i && !restart &&
              (cnt_nxt >= {1'b0, limit_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      limit_q <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      mode_q  <= mode_i;
      limit_q <= limit_i;
      armed_q <= (mode_i != MODE_OFF);
      run_q   <= (mode_i == MODE_IWT);
    end else if (restart) begin
      run_q   <= 1'b1;
    end else if (stop) begin
      run_q   <= 1'b0;
    end else if (expire) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (expire)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign cnt_clr_o = load_i || restart;
  assign cnt_en_o  = etu_tick_i && run_q;
  assign irq_o     = irq_q;

  // R5
  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R6
  a_r6_stay_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !load_i) |=> !run_q);
  // R2: interrupt only from a running timer
  a_r2_irq_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(run_q));
  // R11
  a_r11_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == MODE_OFF) |=> (!armed_q && !run_q));
endmodule

// File: rtl/sc_guard_gate.sv
module sc_guard_gate
  import sc_wgt_pkg::*;
#(
  parameter int unsigned GT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            etu_tick_i,
  input  logic            rx_start_i,
  input  logic            tx_start_i,
  input  logic [GT_W-1:0] egt_i,
  input  logic [GT_W-1:0] bgt_i,
  output logic            permit_o
);
  localparam int unsigned GCW = $clog2(CHAR_ETU + (1 << GT_W));
  localparam int unsigned NG  = 2;  // 0: character guard, 1: block guard

  logic [NG-1:0]  evt, done;
  logic [GCW-1:0] target [NG];
  logic [GCW-1:0] cnt    [NG];

  assign evt[0]    = tx_start_i;
  assign evt[1]    = rx_start_i;
  assign target[0] = GCW'(CHAR_ETU) + GCW'(egt_i);
  assign target[1] = GCW'(bgt_i);

  for (genvar g = 0; g < NG; g++) begin : g_guard
    sc_etu_cnt #(.W(GCW), .RST_MAX(1'b1)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (evt[g]),
      .en_i   (etu_tick_i),
      .cnt_o  (cnt[g])
    );
    assign done[g] = (cnt[g] >= target[g]);
  end

  assign permit_o = &done;

  // R7
  a_r7_tx_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !permit_o);
  // R9
  a_r9_both_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> (cnt[0] >= GCW'(CHAR_ETU)));
endmodule

// File: rtl/sc_wait_guard_timer.sv
module sc_wait_guard_timer
  import sc_wgt_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned GT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             etu_tick_i,
  input  logic             rx_start_i,
  input  logic             tx_start_i,
  input  logic             tx_last_i,
  input  logic [1:0]       mode_i,
  input  logic             wait_load_i,
  input  logic [CNT_W-1:0] wait_val_i,
  input  logic             irq_clr_i,
  input  logic [GT_W-1:0]  egt_i,
  input  logic [GT_W-1:0]  bgt_i,
  output logic             timeout_irq_o,
  output logic             tx_permit_o
);
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] wait_cnt;

  sc_etu_cnt #(.W(CNT_W), .RST_MAX(1'b0)) u_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .cnt_o  (wait_cnt)
  );

  sc_wait_ctrl #(.CNT_W(CNT_W)) u_wait_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .etu_tick_i (etu_tick_i),
    .rx_start_i (rx_start_i),
    .tx_start_i (tx_start_i),
    .tx_last_i  (tx_last_i),
    .mode_i     (wait_mode_e'(mode_i)),
    .load_i     (wait_load_i),
    .limit_i    (wait_val_i),
    .irq_clr_i  (irq_clr_i),
    .cnt_i      (wait_cnt),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .irq_o      (timeout_irq_o)
  );

  sc_guard_gate #(.GT_W(GT_W)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .etu_tick_i (etu_tick_i),
    .rx_start_i (rx_start_i),
    .tx_start_i (tx_start_i),
    .egt_i      (egt_i),
    .bgt_i      (bgt_i),
    .permit_o   (tx_permit_o)
  );
endmodule

// File: tb/sc_wait_guard_timer_tb_top.sv
module sc_wait_guard_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, rx_st = 0, tx_st = 0, tx_last = 0, load = 0, clr = 0;
  logic [1:0]  mode = 2'b11;
  logic [23:0] wval = '0;
  logic [7:0]  egt = '0, bgt = '0;
  logic        irq, permit;
  int          n_chk = 0, n_fail = 0;
  bit          done_flag = 0;

  always #2 clk = ~clk;  // 250 MHz

  sc_wait_guard_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .etu_tick_i(tick), .rx_start_i(rx_st),
    .tx_start_i(tx_st), .tx_last_i(tx_last), .mode_i(mode),
    .wait_load_i(load), .wait_val_i(wval), .irq_clr_i(clr),
    .egt_i(egt), .bgt_i(bgt), .timeout_irq_o(irq), .tx_permit_o(permit)
  );

  // {mode[34:33], limit[32:9], ticks[8:1], expected irq[0]}
  localparam int NV = 10;
  localparam logic [34:0] VEC [NV] = '{
    {2'b10, 24'd5, 8'd4, 1'b0}, {2'b10, 24'd5, 8'd5, 1'b1},
    {2'b00, 24'd3, 8'd2, 1'b0}, {2'b00, 24'd3, 8'd3, 1'b1},
    {2'b01, 24'd7, 8'd6, 1'b0}, {2'b01, 24'd7, 8'd7, 1'b1},
    {2'b10, 24'd0, 8'd1, 1'b1}, {2'b11, 24'd2, 8'd5, 1'b0},
    {2'b10, 24'd1, 8'd1, 1'b1}, {2'b00, 24'd0, 8'd1, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic do_load(input logic [1:0] m, input logic [23:0] v);
    @(negedge clk) begin mode = m; wval = v; load = 1; end
    @(negedge clk) load = 0;
  endtask

  task automatic pulse_rx();
    @(negedge clk) rx_st = 1;
    @(negedge clk) rx_st = 0;
  endtask

  task automatic pulse_tx(input logic last);
    @(negedge clk) begin tx_st = 1; tx_last = last; end
    @(negedge clk) begin tx_st = 0; tx_last = 0; end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 1'b0);
    check("R1 permit", permit, 1'b1);
    ticks(3);
    check("R1 idle timer", irq, 1'b0);

    // Vector walk: R2 R3 R4 R11 R12
    for (int v = 0; v < NV; v++) begin
      pulse_clr();
      do_load(VEC[v][34:33], VEC[v][32:9]);
      if (VEC[v][34:33] == 2'b00) pulse_rx();
      if (VEC[v][34:33] == 2'b01) pulse_tx(1'b1);
      ticks(int'(VEC[v][8:1]));
      check($sformatf("R2/R3/R4/R11/R12 vec%0d", v), irq, VEC[v][0]);
    end

    // R3: restart on each start bit
    pulse_clr();
    do_load(2'b00, 24'd4);
    pulse_rx(); ticks(3);
    pulse_rx(); ticks(3);
    check("R3 restart", irq, 1'b0);
    ticks(1);
    check("R3 expire", irq, 1'b1);

    // R4: non-last tx ignored, rx stops
    pulse_clr();
    do_load(2'b01, 24'd3);
    pulse_tx(1'b0); ticks(5);
    check("R4 non-last ignored", irq, 1'b0);
    pulse_tx(1'b1); ticks(2); pulse_rx(); ticks(5);
    check("R4 rx stops", irq, 1'b0);

    // R2: rx stops initial wait
    do_load(2'b10, 24'd3);
    ticks(1); pulse_rx(); ticks(4);
    check("R2 rx stops", irq, 1'b0);

    // R10: no strobe, no progress
    do_load(2'b10, 24'd2);
    repeat (20) @(negedge clk);
    check("R10 wait hold", irq, 1'b0);
    ticks(2);
    check("R10 wait then expire", irq, 1'b1);

    // R5: sticky and set-over-clear
    repeat (5) @(negedge clk);
    check("R5 sticky", irq, 1'b1);
    do_load(2'b10, 24'd2);
    ticks(1);
    @(negedge clk) begin tick = 1; clr = 1; end
    @(negedge clk) begin tick = 0; clr = 0; end
    check("R5 set wins", irq, 1'b1);
    pulse_clr();
    check("R5 cleared", irq, 1'b0);

    // R6: stopped after expiry until reload
    do_load(2'b00, 24'd2);
    pulse_rx(); ticks(2);
    check("R6 expire", irq, 1'b1);
    pulse_clr();
    pulse_rx(); ticks(10);
    check("R6 ignored after expiry", irq, 1'b0);
    do_load(2'b00, 24'd2);
    pulse_rx(); ticks(2);
    check("R6 reload works", irq, 1'b1);

    // Guard tests: settle counters first
    egt = 8'd0; bgt = 8'd0;
    ticks(20);
    check("R9 idle permit", permit, 1'b1);

    // R7
    egt = 8'd2;
    pulse_tx(1'b0);
    check("R7 drop", permit, 1'b0);
    ticks(13);
    check("R7 before 14", permit, 1'b0);
    ticks(1);
    check("R7 at 14", permit, 1'b1);

    // R10 on guard
    pulse_tx(1'b0);
    repeat (30) @(negedge clk);
    check("R10 guard hold", permit, 1'b0);
    ticks(14);
    check("R10 guard release", permit, 1'b1);

    // R8
    bgt = 8'd5;
    pulse_rx();
    check("R8 drop", permit, 1'b0);
    ticks(4);
    check("R8 before 5", permit, 1'b0);
    ticks(1);
    check("R8 at 5", permit, 1'b1);
    bgt = 8'd0;
    pulse_rx();
    check("R8 zero bgt", permit, 1'b1);

    // R9: both guards, block longer
    egt = 8'd0; bgt = 8'd20;
    @(negedge clk) begin tx_st = 1; rx_st = 1; end
    @(negedge clk) begin tx_st = 0; rx_st = 0; end
    ticks(12);
    check("R9 char done, block pending", permit, 1'b0);
    ticks(8);
    check("R9 both done", permit, 1'b1);

    done_flag = 1;
    finish_run();
  end
endmodule